// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block is the presentation stage that sits in front of one processor. It keeps a single pending slot that holds either a device interrupt or an inter-processor request. It compares that slot with the processor's current priority and drives the external-interrupt line. Priorities are 8-bit values, and a smaller value is more favored. The value 0xFF stands for "nothing". The source id 2 is reserved for the inter-processor request.

Five request channels enter the block: accept, end-of-interrupt, set current priority, set inter-processor priority, and deliver. Each channel is a valid/ready pair. Only one request is taken per clock. When several channels are valid together, accept wins, then end-of-interrupt, then set current priority, then set inter-processor priority, then deliver. A channel whose ready is low must hold its valid and data until ready goes high. All results leave the block as single-cycle pulses, registered one clock after the request is taken, and carry no back-pressure:
- the accept return word;
- a reject pulse carrying a displaced source id;
- a resend pulse, which tells the source side to retry interrupts it was refused;
- an end-of-interrupt strobe toward the source controller.

A displaced or refused device interrupt is never dropped silently. It is either handed back as a reject or recorded in the need-resend flag.

Top module: `irq_presenter`

## Requirements
- R1: A delivery succeeds only when the current priority, the inter-processor priority and the pending priority are all numerically greater than the incoming priority. On success the slot takes the new id and priority, and the previous id is offered as a reject.
- R2: A refused delivery leaves the slot, the current priority and the interrupt line unchanged and sets the need-resend flag.
- R3: irq_out is high exactly when the pending id is non-zero and the pending priority is smaller than the current priority. It follows the state in the same cycle the state changes.
- R4: Accept returns {current priority[7:0], pending id[23:0]} on xirr_data with xirr_valid one clock later. If the id was non-zero, the current priority takes the pending priority, the pending priority becomes 0xFF and the id becomes 0. Otherwise nothing changes.
- R5: Set inter-processor priority stores the value. If the value is below the current priority and no greater than the pending priority, the old id is offered as a reject, the id becomes 2 and the pending priority becomes the value.
- R6: When the new inter-processor priority is greater than the old one, the need-resend flag is cleared, and resend_pulse fires if the flag was set.
- R7: Lowering path (set current priority with a larger value): the current priority is loaded. If the inter-processor priority is below the new value and no greater than the pending priority, the request with id 2 is placed in the slot, and any other id it displaces is offered as a reject. The need-resend flag is then cleared and pulsed if it was set.
- R8: Set current priority with a smaller value loads it. If the value is no greater than the pending priority, the id is offered as a reject and cleared, and the pending priority becomes 0xFF.
- R9: Set current priority with the value already held has no effect: no pulse, and the state is unchanged.
- R10: End-of-interrupt takes word bits [31:24] through the lowering path, whatever their value. It emits eoi_fwd_valid with bits [23:0] unless those bits equal 2.
- R11: A reject whose id is 0 or 2 is not emitted.
- R12: After reset the current priority is 0x00, the inter-processor and pending priorities are 0xFF, the id is 0 and need-resend is clear.
- R13: Ready is high on the highest-priority valid channel only, in the order accept, end-of-interrupt, set current, set inter-processor, deliver.
- R14: Every output pulse lasts exactly one clock per taken request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Accept request |
| acc_ready | output | 1 | Accept taken this clock |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_ready | output | 1 | End-of-interrupt taken |
| eoi_word | input | 32 | New current priority [31:24], source id [23:0] |
| cppr_valid | input | 1 | Set-current-priority request |
| cppr_ready | output | 1 | Set-current-priority taken |
| cppr_val | input | 8 | New current priority |
| mfrr_valid | input | 1 | Set-inter-processor-priority request |
| mfrr_ready | output | 1 | Set-inter-processor-priority taken |
| mfrr_val | input | 8 | New inter-processor priority |
| dlv_valid | input | 1 | Deliver request |
| dlv_ready | output | 1 | Deliver taken |
| dlv_id | input | 24 | Delivered source id |
| dlv_pri | input | 8 | Delivered priority |
| irq_out | output | 1 | External-interrupt line |
| xirr_valid | output | 1 | Accept return pulse |
| xirr_data | output | 32 | Accept return word |
| rej_valid | output | 1 | Reject pulse |
| rej_id | output | 24 | Rejected source id |
| resend_pulse | output | 1 | Retry refused interrupts |
| eoi_fwd_valid | output | 1 | End-of-interrupt strobe to the source side |
| eoi_fwd_id | output | 24 | Source id being completed |

## Verification
The hardest situation to reach from the ports is the one where a resend or a displacing reject depends on history. Examples are a need-resend flag that was set several requests earlier, or an inter-processor request sitting in the slot when the current priority is lowered. The bench gets there in two ways. The first is an exhaustive sweep over current priority, inter-processor priority and delivered priority, each followed by accept. The second is a long random sequence of all five request kinds over a small value set near the priority boundaries, compared request by request against a model built from the requirements.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_ACCEPT  = 3'd1,
    OP_EOI     = 3'd2,
    OP_CPPR    = 3'd3,
    OP_MFRR    = 3'd4,
    OP_DELIVER = 3'd5
  } ipres_op_e;

  // channel index equals arbitration rank, lowest wins
  localparam int unsigned CHAN_N     = 5;
  localparam int unsigned CH_ACCEPT  = 0;
  localparam int unsigned CH_EOI     = 1;
  localparam int unsigned CH_CPPR    = 2;
  localparam int unsigned CH_MFRR    = 3;
  localparam int unsigned CH_DELIVER = 4;

  function automatic ipres_op_e grant_op(input logic [CHAN_N-1:0] g);
    ipres_op_e r;
    r = OP_IDLE;
    for (int i = CHAN_N - 1; i >= 0; i--) begin
      if (g[i]) r = ipres_op_e'(3'(i + 1));
    end
    return r;
  endfunction

endpackage

// File: rtl/ipres_arbiter.sv
module ipres_arbiter #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign gnt[i]       = req[i] & ~taken[i];
    assign taken[i + 1] = taken[i] | req[i];
  end

endmodule

// File: rtl/ipres_core.sv
module ipres_core
  import ipres_pkg::*;
#(
  parameter int unsigned ID_W   = 24,
  parameter int unsigned PRI_W  = 8,
  parameter int unsigned IPI_ID = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ipres_op_e                op,
  input  logic [ID_W-1:0]          arg_id,
  input  logic [PRI_W-1:0]         arg_pri,
  output logic                     irq_out,
  output logic                     ev_rej,
  output logic [ID_W-1:0]          ev_rej_id,
  output logic                     ev_resend,
  output logic                     ev_acc,
  output logic [PRI_W+ID_W-1:0]    ev_acc_data,
  output logic                     ev_eoi,
  output logic [ID_W-1:0]          ev_eoi_id
);

  localparam logic [PRI_W-1:0] PRI_NONE = {PRI_W{1'b1}};
  localparam logic [ID_W-1:0]  ID_IPI   = ID_W'(IPI_ID);
  localparam logic [ID_W-1:0]  ID_NONE  = '0;

  logic [PRI_W-1:0] cppr_q, mfrr_q, ppri_q;
  logic [ID_W-1:0]  xisr_q;
  logic             nr_q;

  logic [PRI_W-1:0] cppr_d, mfrr_d, ppri_d;
  logic [ID_W-1:0]  xisr_d;
  logic             nr_d;

  logic             do_lower;
  logic [PRI_W-1:0] lower_val;
  logic [ID_W-1:0]  disp_id;
  logic             dlv_ok;

  assign dlv_ok = (cppr_q > arg_pri) && (mfrr_q > arg_pri) && (ppri_q > arg_pri);

  always_comb begin
    cppr_d      = cppr_q;
    mfrr_d      = mfrr_q;
    ppri_d      = ppri_q;
    xisr_d      = xisr_q;
    nr_d        = nr_q;
    do_lower    = 1'b0;
    lower_val   = arg_pri;
    disp_id     = ID_NONE;
    ev_resend   = 1'b0;
    ev_acc      = 1'b0;
    ev_acc_data = {cppr_q, xisr_q};
    ev_eoi      = 1'b0;
    ev_eoi_id   = arg_id;

    unique case (op)
      OP_ACCEPT: begin
        ev_acc = 1'b1;
        if (xisr_q != ID_NONE) begin
          cppr_d = ppri_q;
          ppri_d = PRI_NONE;
          xisr_d = ID_NONE;
        end
      end
      OP_EOI: begin
        do_lower = 1'b1;
        ev_eoi   = (arg_id != ID_IPI);
      end
      OP_CPPR: begin
        if (arg_pri > cppr_q) begin
          do_lower = 1'b1;
        end else if (arg_pri < cppr_q) begin
          cppr_d = arg_pri;
          if (arg_pri <= ppri_q) begin
            disp_id = xisr_q;
            xisr_d  = ID_NONE;
            ppri_d  = PRI_NONE;
          end
        end
      end
      OP_MFRR: begin
        mfrr_d = arg_pri;
        if ((arg_pri < cppr_q) && (arg_pri <= ppri_q)) begin
          disp_id = xisr_q;
          xisr_d  = ID_IPI;
          ppri_d  = arg_pri;
        end
        if (arg_pri > mfrr_q) begin
          ev_resend = nr_q;
          nr_d      = 1'b0;
        end
      end
      OP_DELIVER: begin
        if (dlv_ok) begin
          disp_id = xisr_q;
          xisr_d  = arg_id;
          ppri_d  = arg_pri;
        end else begin
          nr_d = 1'b1;
        end
      end
      default: ;
    endcase

    // shared lowering path for end-of-interrupt and set-current-larger
    if (do_lower) begin
      cppr_d = lower_val;
      if ((mfrr_q < lower_val) && (mfrr_q <= ppri_q)) begin
        disp_id = xisr_q;
        xisr_d  = ID_IPI;
        ppri_d  = mfrr_q;
      end
      ev_resend = nr_q;
      nr_d      = 1'b0;
    end
  end

  assign ev_rej    = (disp_id != ID_NONE) && (disp_id != ID_IPI);
  assign ev_rej_id = disp_id;
  assign irq_out   = (xisr_q != ID_NONE) && (ppri_q < cppr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0;
      mfrr_q <= PRI_NONE;
      ppri_q <= PRI_NONE;
      xisr_q <= ID_NONE;
      nr_q   <= 1'b0;
    end else begin
      cppr_q <= cppr_d;
      mfrr_q <= mfrr_d;
      ppri_q <= ppri_d;
      xisr_q <= xisr_d;
      nr_q   <= nr_d;
    end
  end

  p_reset_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cppr_q == '0 && mfrr_q == PRI_NONE && ppri_q == PRI_NONE
                      && xisr_q == ID_NONE && !nr_q));

  p_deliver_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DELIVER && !dlv_ok) |=> (nr_q && $stable(xisr_q) && $stable(cppr_q)));

  p_deliver_raises_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DELIVER && dlv_ok && arg_id != ID_NONE) |=> irq_out);

  p_accept_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ACCEPT && xisr_q != ID_NONE) |=> (xisr_q == ID_NONE && ppri_q == PRI_NONE && !irq_out));

  p_equal_cppr_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CPPR && arg_pri == cppr_q) |=>
      ($stable(cppr_q) && $stable(xisr_q) && $stable(ppri_q) && $stable(nr_q)));

  p_raise_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CPPR && arg_pri < cppr_q && arg_pri <= ppri_q) |=> (xisr_q == ID_NONE && !irq_out));

  p_lower_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EOI) |=> !nr_q);

endmodule

// File: rtl/ipres_evreg.sv
module ipres_evreg #(
  parameter int unsigned ID_W   = 24,
  parameter int unsigned PRI_W  = 8,
  parameter int unsigned IPI_ID = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_rej,
  input  logic [ID_W-1:0]       in_rej_id,
  input  logic                  in_resend,
  input  logic                  in_acc,
  input  logic [PRI_W+ID_W-1:0] in_acc_data,
  input  logic                  in_eoi,
  input  logic [ID_W-1:0]       in_eoi_id,
  output logic                  rej_valid,
  output logic [ID_W-1:0]       rej_id,
  output logic                  resend_pulse,
  output logic                  xirr_valid,
  output logic [PRI_W+ID_W-1:0] xirr_data,
  output logic                  eoi_fwd_valid,
  output logic [ID_W-1:0]       eoi_fwd_id
);

  localparam logic [ID_W-1:0] ID_IPI = ID_W'(IPI_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_valid     <= 1'b0;
      rej_id        <= '0;
      resend_pulse  <= 1'b0;
      xirr_valid    <= 1'b0;
      xirr_data     <= '0;
      eoi_fwd_valid <= 1'b0;
      eoi_fwd_id    <= '0;
    end else begin
      rej_valid     <= in_rej;
      resend_pulse  <= in_resend;
      xirr_valid    <= in_acc;
      eoi_fwd_valid <= in_eoi;
      if (in_rej) rej_id     <= in_rej_id;
      if (in_acc) xirr_data  <= in_acc_data;
      if (in_eoi) eoi_fwd_id <= in_eoi_id;
    end
  end

  p_reject_id_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_id != '0 && rej_id != ID_IPI));

  p_no_ipi_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fwd_valid |-> (eoi_fwd_id != ID_IPI));

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import ipres_pkg::*;
#(
  parameter int unsigned ID_W   = 24,
  parameter int unsigned PRI_W  = 8,
  parameter int unsigned IPI_ID = 2,
  localparam int unsigned WORD_W = PRI_W + ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              eoi_valid,
  output logic              eoi_ready,
  input  logic [WORD_W-1:0] eoi_word,
  input  logic              cppr_valid,
  output logic              cppr_ready,
  input  logic [PRI_W-1:0]  cppr_val,
  input  logic              mfrr_valid,
  output logic              mfrr_ready,
  input  logic [PRI_W-1:0]  mfrr_val,
  input  logic              dlv_valid,
  output logic              dlv_ready,
  input  logic [ID_W-1:0]   dlv_id,
  input  logic [PRI_W-1:0]  dlv_pri,
  output logic              irq_out,
  output logic              xirr_valid,
  output logic [WORD_W-1:0] xirr_data,
  output logic              rej_valid,
  output logic [ID_W-1:0]   rej_id,
  output logic              resend_pulse,
  output logic              eoi_fwd_valid,
  output logic [ID_W-1:0]   eoi_fwd_id
);

  logic [CHAN_N-1:0] req, gnt;
  ipres_op_e         op;
  logic [ID_W-1:0]   arg_id;
  logic [PRI_W-1:0]  arg_pri;

  logic              ev_rej, ev_resend, ev_acc, ev_eoi;
  logic [ID_W-1:0]   ev_rej_id, ev_eoi_id;
  logic [WORD_W-1:0] ev_acc_data;

  assign req[CH_ACCEPT]  = acc_valid;
  assign req[CH_EOI]     = eoi_valid;
  assign req[CH_CPPR]    = cppr_valid;
  assign req[CH_MFRR]    = mfrr_valid;
  assign req[CH_DELIVER] = dlv_valid;

  ipres_arbiter #(.N(CHAN_N)) u_arb (
    .req (req),
    .gnt (gnt)
  );

  assign acc_ready  = gnt[CH_ACCEPT];
  assign eoi_ready  = gnt[CH_EOI];
  assign cppr_ready = gnt[CH_CPPR];
  assign mfrr_ready = gnt[CH_MFRR];
  assign dlv_ready  = gnt[CH_DELIVER];

  assign op = grant_op(gnt);

  always_comb begin
    arg_id  = dlv_id;
    arg_pri = dlv_pri;
    unique case (op)
      OP_EOI: begin
        arg_id  = eoi_word[ID_W-1:0];
        arg_pri = eoi_word[WORD_W-1:ID_W];
      end
      OP_CPPR: arg_pri = cppr_val;
      OP_MFRR: arg_pri = mfrr_val;
      default: ;
    endcase
  end

  ipres_core #(.ID_W(ID_W), .PRI_W(PRI_W), .IPI_ID(IPI_ID)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .arg_id      (arg_id),
    .arg_pri     (arg_pri),
    .irq_out     (irq_out),
    .ev_rej      (ev_rej),
    .ev_rej_id   (ev_rej_id),
    .ev_resend   (ev_resend),
    .ev_acc      (ev_acc),
    .ev_acc_data (ev_acc_data),
    .ev_eoi      (ev_eoi),
    .ev_eoi_id   (ev_eoi_id)
  );

  ipres_evreg #(.ID_W(ID_W), .PRI_W(PRI_W), .IPI_ID(IPI_ID)) u_evreg (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_rej        (ev_rej),
    .in_rej_id     (ev_rej_id),
    .in_resend     (ev_resend),
    .in_acc        (ev_acc),
    .in_acc_data   (ev_acc_data),
    .in_eoi        (ev_eoi),
    .in_eoi_id     (ev_eoi_id),
    .rej_valid     (rej_valid),
    .rej_id        (rej_id),
    .resend_pulse  (resend_pulse),
    .xirr_valid    (xirr_valid),
    .xirr_data     (xirr_data),
    .eoi_fwd_valid (eoi_fwd_valid),
    .eoi_fwd_id    (eoi_fwd_id)
  );

  p_one_op_taken_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && $past(acc_valid) && $past(dlv_valid) && dlv_valid) |-> !dlv_ready);

  p_pulse_single_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (xirr_valid && !$past(acc_ready)) |-> 1'b0);

endmodule

// File: tb/irq_presenter_test.sv
`timescale 1ns/10ps
module irq_presenter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, eoi_valid = 0, cppr_valid = 0, mfrr_valid = 0, dlv_valid = 0;
  logic        acc_ready, eoi_ready, cppr_ready, mfrr_ready, dlv_ready;
  logic [31:0] eoi_word = '0;
  logic [7:0]  cppr_val = '0, mfrr_val = '0, dlv_pri = '0;
  logic [23:0] dlv_id = '0;
  logic        irq_out, xirr_valid, rej_valid, resend_pulse, eoi_fwd_valid;
  logic [31:0] xirr_data;
  logic [23:0] rej_id, eoi_fwd_id;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_word(eoi_word),
    .cppr_valid(cppr_valid), .cppr_ready(cppr_ready), .cppr_val(cppr_val),
    .mfrr_valid(mfrr_valid), .mfrr_ready(mfrr_ready), .mfrr_val(mfrr_val),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_id(dlv_id), .dlv_pri(dlv_pri),
    .irq_out(irq_out), .xirr_valid(xirr_valid), .xirr_data(xirr_data),
    .rej_valid(rej_valid), .rej_id(rej_id), .resend_pulse(resend_pulse),
    .eoi_fwd_valid(eoi_fwd_valid), .eoi_fwd_id(eoi_fwd_id)
  );

  // requirement model
  logic [7:0]  m_cppr, m_mfrr, m_ppri;
  logic [23:0] m_xisr;
  logic        m_nr;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {acc_valid, eoi_valid, cppr_valid, mfrr_valid, dlv_valid} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cppr = 8'h00; m_mfrr = 8'hFF; m_ppri = 8'hFF; m_xisr = '0; m_nr = 1'b0;
  endtask

  // kind: 1 accept, 2 eoi, 3 set current, 4 set ipi, 5 deliver. Called just after a negedge.
  task automatic run_op(input int kind, input logic [23:0] id, input logic [7:0] pr);
    logic        e_acc, e_eoi, e_res, lower, e_rej;
    logic [31:0] e_accd;
    logic [23:0] disp, e_eid;
    logic [7:0]  old_m;
    string       tag;
    e_acc = 0; e_accd = '0; e_eoi = 0; e_eid = '0; e_res = 0; lower = 0; disp = '0;
    case (kind)
      1: begin
        tag = "R4"; e_acc = 1; e_accd = {m_cppr, m_xisr};
        if (m_xisr != 0) begin m_cppr = m_ppri; m_ppri = 8'hFF; m_xisr = '0; end
      end
      2: begin
        tag = "R10"; lower = 1;
        if (id != 24'd2) begin e_eoi = 1; e_eid = id; end
      end
      3: begin
        if (pr > m_cppr) begin tag = "R7"; lower = 1; end
        else if (pr < m_cppr) begin
          tag = "R8"; m_cppr = pr;
          if (pr <= m_ppri) begin disp = m_xisr; m_xisr = '0; m_ppri = 8'hFF; end
        end else tag = "R9";
      end
      4: begin
        tag = "R5"; old_m = m_mfrr; m_mfrr = pr;
        if (pr < m_cppr && pr <= m_ppri) begin disp = m_xisr; m_xisr = 24'd2; m_ppri = pr; end
        if (pr > old_m) begin e_res = m_nr; m_nr = 0; end
      end
      default: begin
        if (m_cppr > pr && m_mfrr > pr && m_ppri > pr) begin
          tag = "R1"; disp = m_xisr; m_xisr = id; m_ppri = pr;
        end else begin tag = "R2"; m_nr = 1; end
      end
    endcase
    if (lower) begin
      m_cppr = pr;
      if (m_mfrr < pr && m_mfrr <= m_ppri) begin disp = m_xisr; m_xisr = 24'd2; m_ppri = m_mfrr; end
      e_res = m_nr; m_nr = 0;
    end
    e_rej = (disp != 0) && (disp != 24'd2);

    case (kind)
      1: acc_valid = 1;
      2: begin eoi_valid = 1; eoi_word = {pr, id}; end
      3: begin cppr_valid = 1; cppr_val = pr; end
      4: begin mfrr_valid = 1; mfrr_val = pr; end
      default: begin dlv_valid = 1; dlv_id = id; dlv_pri = pr; end
    endcase
    @(posedge clk);
    @(negedge clk);
    {acc_valid, eoi_valid, cppr_valid, mfrr_valid, dlv_valid} = '0;
    check({tag, " accept pulse"}, 32'(xirr_valid), 32'(e_acc));
    if (e_acc) check("R4 accept word", xirr_data, e_accd);
    check("R11 reject pulse", 32'(rej_valid), 32'(e_rej));
    if (e_rej) check({tag, " reject id"}, 32'(rej_id), 32'(disp));
    check("R6 resend pulse", 32'(resend_pulse), 32'(e_res));
    check("R10 eoi strobe", 32'(eoi_fwd_valid), 32'(e_eoi));
    if (e_eoi) check("R10 eoi id", 32'(eoi_fwd_id), 32'(e_eid));
    check({tag, " R3 irq line"}, 32'(irq_out),
          32'((m_xisr != 0) && (m_ppri < m_cppr)));
  endtask

  function automatic logic [7:0] pick_pri(input int unsigned r);
    case (r % 9)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h03;
      4: return 8'h04; 5: return 8'h05; 6: return 8'h06; 7: return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [23:0] pick_id(input int unsigned r);
    case (r % 6)
      0: return 24'd0; 1: return 24'd1; 2: return 24'd2;
      3: return 24'd3; 4: return 24'd7; default: return 24'hABCDE;
    endcase
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [6];
    vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h02;
    vals[3] = 8'h03; vals[4] = 8'hFE; vals[5] = 8'hFF;

    // R12: reset state seen through the ports
    do_reset();
    check("R12 irq low after reset", 32'(irq_out), 32'd0);
    check("R12 no pulses after reset", 32'({xirr_valid, rej_valid, resend_pulse, eoi_fwd_valid}), 32'd0);
    run_op(1, 0, 0);                 // returns {00, 000000}
    run_op(5, 24'd9, 8'hFE);          // refused: current priority is 0
    run_op(3, 0, 8'hFF);              // lowering path releases the refusal
    run_op(5, 24'd9, 8'hFE);          // accepted since ipi and pending are 0xFF
    check("R12 pending and ipi start at FF", 32'(irq_out), 32'd1);

    // R2 then R6: refusal recorded and released by a less-favored ipi priority
    do_reset();
    run_op(4, 0, 8'h10);
    run_op(5, 24'd5, 8'h08);
    check("R2 refused delivery keeps line low", 32'(irq_out), 32'd0);
    run_op(4, 0, 8'h20);
    run_op(4, 0, 8'h30);             // flag already cleared, no pulse

    // R9 and R8
    do_reset();
    run_op(3, 0, 8'h05);
    run_op(5, 24'd9, 8'h03);
    run_op(3, 0, 8'h05);
    check("R9 equal value keeps line", 32'(irq_out), 32'd1);
    run_op(3, 0, 8'h03);
    check("R8 raise drops line", 32'(irq_out), 32'd0);
    run_op(1, 0, 0);

    // R10 and R7: eoi with ipi id, ipi placed on lowering
    do_reset();
    run_op(3, 0, 8'h04);
    run_op(4, 0, 8'h06);
    run_op(2, 24'd2, 8'h08);
    run_op(1, 0, 0);
    run_op(2, 24'd3, 8'hFF);

    // R14: pulses last one cycle
    do_reset();
    run_op(3, 0, 8'h08);
    run_op(5, 24'd4, 8'h02);
    run_op(5, 24'd6, 8'h01);
    check("R14 reject pulse present", 32'(rej_valid), 32'd1);
    @(negedge clk);
    check("R14 reject pulse single cycle", 32'(rej_valid), 32'd0);

    // R13: arbitration over every combination of valids
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      {dlv_valid, mfrr_valid, cppr_valid, eoi_valid, acc_valid} = 5'(v);
      #1;
      begin
        logic [4:0] exp_g;
        exp_g = 5'(v) & (~5'(v) + 5'd1);
        check("R13 ready follows rank", 32'({dlv_ready, mfrr_ready, cppr_ready, eoi_ready, acc_ready}),
              32'(exp_g));
      end
      {acc_valid, eoi_valid, cppr_valid, mfrr_valid, dlv_valid} = '0;
    end

    // exhaustive sweep over current, ipi and delivered priority
    for (int c = 0; c < 6; c++) begin
      for (int m = 0; m < 6; m++) begin
        for (int p = 0; p < 6; p++) begin
          do_reset();
          run_op(3, 0, vals[c]);
          run_op(4, 0, vals[m]);
          run_op(5, 24'd5, vals[p]);
          run_op(1, 0, 0);
          run_op(2, 24'd5, vals[(c + p) % 6]);
        end
      end
    end

    // long random sequence compared against the model
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      int unsigned r;
      r = $urandom;
      run_op(int'(r % 5) + 1, pick_id(r >> 4), pick_pri(r >> 12));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule